// File: doc/BRIEF.md
# Byte-wide one-time-programmable memory core

This block is a synthesizable behavioural model of a byte-wide memory that can be written only once per bit. Every cell leaves reset at logic 1. A programming pulse can only pull bits to 0, so each write stores the old byte ANDed with the new one. The address width is a parameter.

The operating mode is decoded each cycle from five inputs: an active-low chip select, an active-low output gate, a flag that says the programming supply is present, a flag that says the identification level is present on an address line, and the address itself. The supported modes are read, output disable, standby, program, program verify, program inhibit and signature readout. Combinations that match no mode are flagged. The byte output has its own enable, so a tri-state pad can be built around it.

A program pulse is seen through the system clock. The pulse's data and address are captured on every clock edge while the pulse lasts. The write is committed on the first clock edge that sees chip select high again, so one pulse makes one write.

Top module: `otp_mem_core`

## Requirements
- R1: With chip select low, output gate low and both flags clear, `dout_en` is 1 and `dout` shows the byte stored at `addr`.
- R2: With chip select low, output gate high and no programming supply, `dout_en` is 0.
- R3: With chip select high and no programming supply, `dout_en` is 0 whatever the output gate and identification flag are.
- R4: With the programming supply present, output gate high and chip select low, a write is captured. It is committed on the first clock edge that samples chip select high while the supply is still present. A pulse that stops being a program pulse before chip select rises writes nothing, and each pulse writes exactly once.
- R5: A committed write stores old AND input byte. Bits can be cleared but never set.
- R6: With the programming supply present, chip select high, output gate low and no identification flag, `dout_en` is 1 and `dout` shows the stored byte (verify).
- R7: With the programming supply present and both enables high, `dout_en` is 0 and the array is not changed (inhibit).
- R8: With the identification flag set, both enables low, no programming supply and every address bit above bit 0 at 0, `dout` is 8'h20 when `addr[0]`=0 and 8'hB4 when `addr[0]`=1, with `dout_en`=1.
- R9: The illegal combinations are: programming supply with both enables low; programming supply together with the identification flag; signature mode with any address bit above bit 0 set. Each one gives `illegal`=1 and `dout_en`=0. Every other combination gives `illegal`=0.
- R10: After reset every byte of the array reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; sets the array to all ones |
| ce_n | input | 1 | Active-low chip select; a low pulse programs |
| oe_n | input | 1 | Active-low output gate |
| vpp_hi | input | 1 | Programming supply present |
| id_hi | input | 1 | Identification level present |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Byte output |
| dout_en | output | 1 | Drive enable for the byte output |
| illegal | output | 1 | Input combination matches no mode |

## Verification
Two functions can fall in the same cycle: the commit of a program pulse and a verify read. A bench provokes this by raising chip select and lowering the output gate on the same clock phase, with the programming supply still present. In that cycle the mode is already verify while the write is still pending. So the bench expects the byte before the write until the commit edge, and the ANDed byte after that edge. Aborted pulses and long inhibit stretches are then judged by a verify read of the same address.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_DISABLE,
    M_READ,
    M_SIG,
    M_PROG,
    M_VERIFY,
    M_INHIBIT,
    M_ILLEGAL
  } otp_mode_e;

  localparam logic [7:0] SIG_BYTE0 = 8'h20;
  localparam logic [7:0] SIG_BYTE1 = 8'hB4;
  localparam logic [7:0] ERASED    = 8'hFF;

  // Programming can only clear bits.
  function automatic logic [7:0] clear_only(input logic [7:0] old_b,
                                            input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] sig_pick(input logic a0);
    return a0 ? SIG_BYTE1 : SIG_BYTE0;
  endfunction

  function automatic otp_mode_e mode_of(input logic ce_n, input logic oe_n,
                                        input logic vpp, input logic idv,
                                        input logic upper_zero);
    otp_mode_e m;
    if (vpp) begin
      if (idv) m = M_ILLEGAL;
      else begin
        case ({ce_n, oe_n})
          2'b00:   m = M_ILLEGAL;
          2'b01:   m = M_PROG;
          2'b10:   m = M_VERIFY;
          default: m = M_INHIBIT;
        endcase
      end
    end else if (ce_n) m = M_STANDBY;
    else if (oe_n)     m = M_DISABLE;
    else if (idv)      m = upper_zero ? M_SIG : M_ILLEGAL;
    else               m = M_READ;
    return m;
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hi,
  input  logic [ADDR_W-1:0] addr,
  output otp_mode_e         mode,
  output logic              bad_combo
);

  logic upper_zero;

  generate
    if (ADDR_W > 1) begin : g_wide
      assign upper_zero = ~|addr[ADDR_W-1:1];
    end else begin : g_narrow
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    mode      = mode_of(ce_n, oe_n, vpp_hi, id_hi, upper_zero);
    bad_combo = (mode == M_ILLEGAL);
  end

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  otp_mode_e         mode,
  input  logic              ce_n,
  input  logic              vpp_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  logic              armed_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [7:0]        pend_data_q;

  // Commit when the previous edge saw a program pulse and this one sees
  // chip select released with the supply still present.
  assign wr_fire = armed_q & ce_n & vpp_hi;
  assign wr_addr = pend_addr_q;
  assign wr_data = pend_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= ERASED;
    end else begin
      armed_q <= (mode == M_PROG);
      if (mode == M_PROG) begin
        pend_addr_q <= addr;
        pend_data_q <= din;
      end
    end
  end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
    end else if (wr_fire) begin
      cells[wr_addr] <= clear_only(cells[wr_addr], wr_data);
    end
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/otp_out_mux.sv
module otp_out_mux
  import otp_pkg::*;
(
  input  otp_mode_e  mode,
  input  logic       a0,
  input  logic [7:0] rd_data,
  output logic [7:0] dout,
  output logic       dout_en
);

  always_comb begin
    dout    = '0;
    dout_en = 1'b0;
    case (mode)
      M_READ, M_VERIFY: begin
        dout    = rd_data;
        dout_en = 1'b1;
      end
      M_SIG: begin
        dout    = sig_pick(a0);
        dout_en = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/otp_mem_core.sv
module otp_mem_core
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              illegal
);

  otp_mode_e         cur_mode;
  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [7:0]        rd_data;

  otp_mode_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .vpp_hi   (vpp_hi),
    .id_hi    (id_hi),
    .addr     (addr),
    .mode     (cur_mode),
    .bad_combo(illegal)
  );

  otp_prog_ctrl #(.ADDR_W(ADDR_W)) u_prog (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (cur_mode),
    .ce_n   (ce_n),
    .vpp_hi (vpp_hi),
    .addr   (addr),
    .din    (din),
    .wr_fire(wr_fire),
    .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  otp_cell_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_fire(wr_fire),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(addr),
    .rd_data(rd_data)
  );

  otp_out_mux u_mux (
    .mode   (cur_mode),
    .a0     (addr[0]),
    .rd_data(rd_data),
    .dout   (dout),
    .dout_en(dout_en)
  );

endmodule

// File: rtl/otp_mem_core_chk.sv
module otp_mem_core_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              id_hi,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dout,
  input logic              dout_en,
  input logic              illegal,
  input logic              wr_fire
);

  logic hi_zero;
  assign hi_zero = ((addr >> 1) == '0);

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi && !id_hi) |-> (dout_en && !illegal));

  assert_disable_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !vpp_hi) |-> !dout_en);

  assert_standby_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !vpp_hi) |-> !dout_en);

  assert_one_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);

  assert_commit_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (ce_n && vpp_hi && $past(!ce_n) && $past(oe_n)));

  assert_verify_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && ce_n && !oe_n && !id_hi) |-> dout_en);

  assert_inhibit_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && ce_n && oe_n) |-> (!dout_en && !wr_fire ? 1'b1 : !dout_en));

  assert_sig_bytes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_hi && !vpp_hi && !ce_n && !oe_n && hi_zero) |->
      (dout_en && (dout == (addr[0] ? 8'hB4 : 8'h20))));

  assert_illegal_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !dout_en);

endmodule

bind otp_mem_core otp_mem_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ce_n   (ce_n),
  .oe_n   (oe_n),
  .vpp_hi (vpp_hi),
  .id_hi  (id_hi),
  .addr   (addr),
  .dout   (dout),
  .dout_en(dout_en),
  .illegal(illegal),
  .wr_fire(wr_fire)
);

// File: tb/test_otp_mem_core.sv
module test_otp_mem_core;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hi = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en, illegal;

  always #2.5 clk = ~clk;

  otp_mem_core #(.ADDR_W(AW)) i_otp_mem_core (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hi(id_hi), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .illegal(illegal)
  );

  typedef struct {
    logic       en;
    logic [7:0] data;
    logic       ill;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] model [DEPTH];
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  // Monitor: pops expected items and compares them with the ports.
  initial begin
    forever begin
      exp_t e;
      wait (sb.size() > 0);
      e = sb.pop_front();
      checks++;
      if (dout_en !== e.en || illegal !== e.ill || (e.en && dout !== e.data)) begin
        errors++;
        $display("FAIL %s: en=%b dout=%h ill=%b expected en=%b dout=%h ill=%b",
                 e.tag, dout_en, dout, illegal, e.en, e.data, e.ill);
      end
    end
  end

  task automatic drive(input logic c, input logic o, input logic v, input logic i,
                       input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; vpp_hi = v; id_hi = i; addr = a; din = d;
  endtask

  task automatic expect_out(input logic en, input logic [7:0] data,
                            input logic ill, input string tag);
    exp_t e;
    #1;
    e.en = en; e.data = data; e.ill = ill; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic pulse(input logic [AW-1:0] a, input logic [7:0] d);
    drive(1'b0, 1'b1, 1'b1, 1'b0, a, d);
    drive(1'b1, 1'b1, 1'b1, 1'b0, a, d);
    model[a] = model[a] & d;
  endtask

  task automatic verify_chk(input logic [AW-1:0] a, input string tag);
    drive(1'b1, 1'b0, 1'b1, 1'b0, a, 8'h00);
    expect_out(1'b1, model[a], 1'b0, tag);
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input string tag);
    drive(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00);
    expect_out(1'b1, model[a], 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: en=%b dout=%h expected run to finish", dout_en, dout);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) model[k] = 8'hFF;
    repeat (3) @(posedge clk);
    expect_out(1'b0, 8'h00, 1'b0, "R3 standby during reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R10 erased state, R1 read
    read_chk(8'd0,   "R10 R1 addr 0 erased");
    read_chk(8'd255, "R10 R1 addr 255 erased");

    // R2 output disable, R3 standby with output gate low
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 8'h00);
    expect_out(1'b0, 8'h00, 1'b0, "R2 disable hi-z");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'h00);
    expect_out(1'b0, 8'h00, 1'b0, "R3 standby gate low");
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'd1, 8'h00);
    expect_out(1'b0, 8'h00, 1'b0, "R3 standby with id flag");

    // R4 R6 program then verify
    pulse(8'd5, 8'hA5);
    verify_chk(8'd5, "R4 R6 verify after pulse");
    // R5 clear only
    pulse(8'd5, 8'h0F);
    verify_chk(8'd5, "R5 AND of 0xA5 and 0x0F");
    pulse(8'd5, 8'hFF);
    verify_chk(8'd5, "R5 ones do not set bits");
    read_chk(8'd5, "R1 read programmed byte");
    read_chk(8'd6, "R4 neighbour untouched");

    // R4 long pulse writes once with final data
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'd20, 8'hF0);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'd20, 8'hF0);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'd20, 8'hF0);
    expect_out(1'b0, 8'h00, 1'b0, "R4 hi-z during pulse");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'd20, 8'hF0);
    model[20] = 8'hF0;
    verify_chk(8'd20, "R4 long pulse result");

    // R4 aborted pulse: supply drops before release
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'd12, 8'h00);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'd12, 8'h00);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'd12, 8'h00);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'd12, 8'h00);
    verify_chk(8'd12, "R4 aborted pulse no write");

    // R7 inhibit held for several cycles with zero data
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'd7, 8'h00);
    expect_out(1'b0, 8'h00, 1'b0, "R7 inhibit hi-z");
    repeat (4) drive(1'b1, 1'b1, 1'b1, 1'b0, 8'd7, 8'h00);
    verify_chk(8'd7, "R7 inhibit leaves byte");

    // R8 signature
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 8'h00);
    expect_out(1'b1, 8'h20, 1'b0, "R8 signature byte 0");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'd1, 8'h00);
    expect_out(1'b1, 8'hB4, 1'b0, "R8 signature byte 1");

    // R9 illegal combinations
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'd2, 8'h00);
    expect_out(1'b0, 8'h00, 1'b1, "R9 signature upper bit set");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'd5, 8'h00);
    expect_out(1'b0, 8'h00, 1'b1, "R9 supply with both enables low");
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'd5, 8'h00);
    expect_out(1'b0, 8'h00, 1'b1, "R9 supply with id flag");
    drive(1'b1, 1'b0, 1'b1, 1'b0, 8'd5, 8'h00);
    expect_out(1'b1, model[5], 1'b0, "R9 legal again clears flag");

    // Same cycle: commit of a pulse and a verify read
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'd9, 8'h3C);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 8'd9, 8'h3C);
    expect_out(1'b1, 8'hFF, 1'b0, "R6 R4 verify before commit edge");
    @(negedge clk);
    model[9] = 8'h3C;
    expect_out(1'b1, 8'h3C, 1'b0, "R6 R5 verify after commit edge");

    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 8'h00);
    wait (sb.size() == 0);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule